// File: doc/BRIEF.md
# Successive-Approximation Conversion Start Controller

This block is the digital control side of a successive-approximation converter. Three control inputs decide when a conversion begins: chip enable (active high), chip select (active low) and read/convert (active low). Each passes through a two-flop synchroniser. A conversion starts on the clock where the combined condition first becomes true, so whichever input arrives last is the one that triggers it. At that start the address bit is captured. It chooses a short (8-bit) or a full (12-bit) conversion.

While the conversion runs, the block drives a trial code one bit at a time, starting at the MSB. A comparator decision input reports whether the analog sample is at or above that trial code. The block keeps or drops the bit under test and holds a busy flag high. At the end the resolved code goes into a result holding register. A short conversion leaves a fixed pad in the low bits of the result. A start condition that arrives during a conversion never restarts it. It does capture the address bit again, and this can change the length of the conversion that is already running.

Top module: `adc_start_ctrl`

## Requirements
- R1: After reset, busy_o is 0, result_o is 0 and trial_o is 0.
- R2: A start requires ce_i=1, cs_ni=0 and rc_ni=0 together. No other combination of these three inputs starts a conversion.
- R3: The start follows the input that completes the condition, whichever of the three it is. busy_o rises on the third rising clock edge after that input changes: two synchroniser stages plus one register.
- R4: a0_i=1 captured at start selects a short conversion, with busy_o high for 8 clock cycles. a0_i=0 selects a full conversion, with busy_o high for 12 cycles.
- R5: While busy, trial_o equals the bits decided so far OR'ed with the bit under test, from bit 11 down to bit 0. cmp_i=1 at a clock edge keeps the bit under test. A full conversion therefore stores the binary-search result, which equals the sample.
- R6: After a short conversion, result_o[11:4] holds the searched bits and result_o[3:0] = 4'b1000.
- R7: A new start condition while busy_o=1 does not reset or restart the conversion. With a0_i unchanged, the busy length and the result are unchanged.
- R8: A new start condition while busy captures a0_i again. Switching to a0_i=1 early enough ends the conversion after 8 bits, with the short-result pad applied.
- R9: A change of a0_i during a conversion that has no new start condition has no effect on length or result.
- R10: result_o changes only on the clock edge where busy_o falls. Between conversions, and during one, it keeps the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable, active high, asynchronous |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| rc_ni | input | 1 | Read/convert, low requests a conversion, asynchronous |
| a0_i | input | 1 | Length select, captured at start: 1 short, 0 full |
| cmp_i | input | 1 | Comparator decision: 1 when sample >= trial_o |
| busy_o | output | 1 | High only while a conversion runs |
| trial_o | output | 12 | Current trial code, 0 when idle |
| result_o | output | 12 | Result holding register |

## Verification
A wrong bit index or a wrong trial code appears at result_o at the end of the conversion, when the stored code differs from the sample. That is at most 12 cycles after busy_o rises. A wrong length capture or a wrong done test shows up on the very conversion it affects, as a busy pulse of the wrong width. A restart that should not happen stretches busy_o beyond 12 cycles. A fault in the start detector or the synchroniser moves the busy rise off the third clock edge, or lets a non-start combination raise busy_o within three cycles.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  typedef enum logic {LEN_FULL = 1'b0, LEN_SHORT = 1'b1} conv_len_e;
endpackage

// File: rtl/adc_sync2.sv
module adc_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/adc_start_detect.sv
module adc_start_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_s_i,
  input  logic cs_n_s_i,
  input  logic rc_n_s_i,
  output logic start_o
);
  logic cond, cond_q;

  assign cond = ce_s_i & ~cs_n_s_i & ~rc_n_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= 1'b0;
    else         cond_q <= cond;
  end

  // last input to arrive makes the rising edge
  assign start_o = cond & ~cond_q;

  a_r2_start_needs_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (ce_s_i && !cs_n_s_i && !rc_n_s_i));
  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_ctrl_pkg::*;
#(
  parameter int RES_W   = 12,
  parameter int SHORT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             a0_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o
);
  localparam int IDX_W = $clog2(RES_W);
  localparam int PAD_W = RES_W - SHORT_W;
  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(RES_W - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAD_W);
  localparam logic [RES_W-1:0] LO_MASK  = (RES_W'(1) << PAD_W) - RES_W'(1);
  localparam logic [RES_W-1:0] PAD      = RES_W'(1) << (PAD_W - 1);

  logic [RES_W-1:0] sar_q, result_q, bit_sel, next_bits;
  logic [IDX_W-1:0] idx_q;
  conv_len_e        len_q;
  logic             busy_q, done;

  assign bit_sel   = RES_W'(1) << idx_q;
  assign next_bits = cmp_i ? (sar_q | bit_sel) : sar_q;
  assign done      = (idx_q == '0) || (len_q == LEN_SHORT && idx_q <= LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      sar_q    <= '0;
      idx_q    <= '0;
      len_q    <= LEN_FULL;
      result_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        sar_q  <= '0;
        idx_q  <= TOP_IDX;
        len_q  <= conv_len_e'(a0_i);
      end
    end else begin
      sar_q <= next_bits;
      if (done) begin
        busy_q   <= 1'b0;
        result_q <= (len_q == LEN_SHORT) ? ((next_bits & ~LO_MASK) | PAD) : next_bits;
      end else begin
        idx_q <= idx_q - 1'b1;
        // redundant start: length re-captured, sequence untouched
        if (start_i) len_q <= conv_len_e'(a0_i);
      end
    end
  end

  assign busy_o   = busy_q;
  assign trial_o  = busy_q ? (sar_q | bit_sel) : '0;
  assign result_o = result_q;

  // busy-cycle counter for the length bound check
  logic [IDX_W:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cyc_q <= '0;
    else if (busy_q) cyc_q <= cyc_q + 1'b1;
    else             cyc_q <= '0;
  end

  a_r2_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_q |=> busy_q && idx_q == TOP_IDX);
  a_r7_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done |=> busy_q && idx_q == $past(idx_q) - 1'b1);
  a_r4_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q <= (IDX_W+1)'(RES_W));
  a_r6_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) && $past(len_q) == LEN_SHORT |-> (result_q & LO_MASK) == PAD);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_q) |-> $stable(result_q));
endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl #(
  parameter int RES_W   = 12,
  parameter int SHORT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             cs_ni,
  input  logic             rc_ni,
  input  logic             a0_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o
);
  logic [3:0] raw, syn;
  logic       start;

  assign raw = {ce_i, cs_ni, rc_ni, a0_i};

  // reset to the inactive control levels
  adc_sync2 #(.W(4), .RST_VAL(4'b0110)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  adc_start_detect u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_s_i  (syn[3]),
    .cs_n_s_i(syn[2]),
    .rc_n_s_i(syn[1]),
    .start_o (start)
  );

  adc_sar_seq #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .a0_i    (syn[0]),
    .cmp_i   (cmp_i),
    .busy_o  (busy_o),
    .trial_o (trial_o),
    .result_o(result_o)
  );

  a_r1_idle_trial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> trial_o == '0);
endmodule

// File: tb/adc_start_ctrl_test.sv
module adc_start_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, cs_n = 1'b1, rc_n = 1'b1, a0 = 1'b0;
  logic [11:0] sample = '0;
  logic cmp, busy;
  logic [11:0] trial, result;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign cmp = (sample >= trial);

  adc_start_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .cs_ni(cs_n), .rc_ni(rc_n),
    .a0_i(a0), .cmp_i(cmp), .busy_o(busy), .trial_o(trial), .result_o(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // mode 0: plain, 1: a0 toggles only, 2: redundant start with a0 = a0_new
  task automatic conv(input logic [11:0] s, input logic a0_start, input int mode,
                      input logic a0_new, input int exp_len, input logic [11:0] exp_res,
                      input string tag);
    int n = 0;
    int k = 3;
    logic [11:0] prev;
    sample = s;
    @(negedge clk); a0 = a0_start; rc_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(busy == 1'b0, "R3 early", int'(busy), 0);
    @(negedge clk);
    chk(busy == 1'b1, "R3 rise", int'(busy), 1);
    prev = result;
    n = 1;
    while (1) begin
      if (mode == 1 && k == 3) a0 = a0_new;
      if (mode == 2 && k == 3) rc_n = 1'b1;
      if (mode == 2 && k == 4) begin rc_n = 1'b0; a0 = a0_new; end
      @(negedge clk); k++;
      if (!busy) break;
      n++;
      if (n == 5) chk(result == prev, "R10 mid", int'(result), int'(prev));
      if (n > 40) break;
    end
    chk(n == exp_len, {tag, " length"}, n, exp_len);
    chk(result == exp_res, {tag, " result"}, int'(result), int'(exp_res));
    rc_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic last_input(input int which);
    ce = (which != 0); cs_n = (which == 1); rc_n = (which == 2); a0 = 1'b0;
    sample = 12'h5A3;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R2 partial", int'(busy), 0);
    if (which == 0) ce = 1'b1;
    if (which == 1) cs_n = 1'b0;
    if (which == 2) rc_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(busy == 1'b0, "R3 last early", int'(busy), 0);
    @(negedge clk);
    chk(busy == 1'b1, "R3 last rise", int'(busy), 1);
    repeat (14) @(negedge clk);
    chk(result == 12'h5A3, "R3 last result", int'(result), 'h5A3);
    ce = 1'b0; cs_n = 1'b1; rc_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(result == 12'h000, "R1 result", int'(result), 0);
    chk(trial == 12'h000, "R1 trial", int'(trial), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: every non-start combination from idle
    for (int c = 0; c < 8; c++) begin
      if (c == 3'b100) continue;
      ce = c[2]; cs_n = c[1]; rc_n = c[0];
      repeat (5) @(negedge clk);
      chk(busy == 1'b0, "R2 no start", int'(busy), 0);
      ce = 1'b0; cs_n = 1'b1; rc_n = 1'b1;
      repeat (3) @(negedge clk);
    end

    // R3: each input as the last one
    for (int w = 0; w < 3; w++) last_input(w);

    ce = 1'b1; cs_n = 1'b0;
    // R4/R5 full conversions
    conv(12'h000, 1'b0, 0, 1'b0, 12, 12'h000, "R4 R5 full");
    conv(12'hFFF, 1'b0, 0, 1'b0, 12, 12'hFFF, "R4 R5 full");
    for (int i = 0; i < 24; i++) begin
      logic [11:0] s = 12'((i * 173 + 5) % 4096);
      conv(s, 1'b0, 0, 1'b0, 12, s, "R5 full sweep");
    end
    // R4/R6 short conversions
    conv(12'h000, 1'b1, 0, 1'b1, 8, 12'h008, "R4 R6 short");
    conv(12'hFFF, 1'b1, 0, 1'b1, 8, 12'hFF8, "R4 R6 short");
    for (int i = 0; i < 24; i++) begin
      logic [11:0] s = 12'((i * 389 + 11) % 4096);
      conv(s, 1'b1, 0, 1'b1, 8, {s[11:4], 4'b1000}, "R6 short sweep");
    end
    // R7 redundant start, same a0
    conv(12'h9C4, 1'b0, 2, 1'b0, 12, 12'h9C4, "R7 no restart");
    conv(12'h3E7, 1'b1, 2, 1'b1, 8, 12'h3E8, "R7 no restart short");
    // R8 redundant start re-captures a0
    conv(12'hB6D, 1'b0, 2, 1'b1, 8, 12'hB68, "R8 recapture short");
    conv(12'h71F, 1'b1, 2, 1'b0, 12, 12'h71F, "R8 recapture full");
    // R9 a0 change without start
    conv(12'h2D9, 1'b0, 1, 1'b1, 12, 12'h2D9, "R9 a0 ignored");
    conv(12'hE35, 1'b1, 1, 1'b0, 8, 12'hE38, "R9 a0 ignored short");

    // R10 hold while idle
    sample = 12'h123;
    repeat (10) @(negedge clk);
    chk(result == 12'hE38, "R10 idle hold", int'(result), 'hE38);
    chk(busy == 1'b0, "R10 idle busy", int'(busy), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule